// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer. The operand arrives as a sign, a class code, a signed unbiased exponent and a normalized significand. The significand carries its leading one in the top bit, and a sticky bit stands for any nonzero bits below the significand. A two-bit rounding mode selects how discarded fraction bits are resolved, and a truncate control forces rounding toward zero. The block registers its outputs. It delivers the integer and four status flags one clock after the operand is presented.

Values that cannot be represented saturate. Positive values clamp to the largest integer, and negative values and every NaN clamp to the most negative integer. Either case raises the invalid-conversion flag and clears any inexact status. The limit depends on the sign: the most negative integer is a legal result, but its positive counterpart is not. Integer width, exponent width and significand width are parameters, and the defaults are 32, 12 and 64.

Top module: `fti_convert`

## Requirements
- R1: Class code 0 (zero) yields result 0 with all four flags clear, whatever the other inputs.
- R2: Class code 4 (signalling NaN) yields the most negative integer with the signalling and invalid flags set. Class code 3 (quiet NaN) and the unused codes 5 to 7 yield the most negative integer with only the invalid flag set.
- R3: Class code 2 (infinity) saturates by sign and sets the invalid flag: largest positive integer when the sign is 0, most negative integer when the sign is 1.
- R4: A normal operand (class code 1) whose exponent is at least the integer width saturates by sign as in R3 and sets the invalid flag.
- R5: Whenever the invalid flag is set, the inexact and rounded-up flags are clear, even if discarded fraction bits were nonzero.
- R6: A normal operand in range returns its magnitude sig/2^(SIG_W-1)*2^exp, rounded to an integer by the mode code: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R7: In mode 0, an exact half (guard bit set, lower bits and sticky clear) rounds up only when the integer part is odd. A guard bit with any lower bit or sticky set always rounds up.
- R8: After rounding, a magnitude of at least 2^(INT_W-1)+sign is an overflow that saturates as in R4. A magnitude of exactly 2^(INT_W-1) is accepted when the sign is 1.
- R9: With the truncate input at 1, the result and flags equal those of mode 1 regardless of the mode input.
- R10: An accepted result is negated when the sign is 1. The inexact flag is set when any discarded bit or the sticky bit is nonzero, and the rounded-up flag is set when the magnitude was incremented.
- R11: Negative exponents are converted normally. The integer part is 0, and rounding may lift the result to 1 in magnitude.
- R12: Outputs update on the rising clock edge after the inputs are applied. A synchronous active-low reset clears the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sign_i | input | 1 | Operand sign, 1 = negative |
| cls_i | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| exp_i | input | EXP_W | Signed unbiased exponent |
| sig_i | input | SIG_W | Significand, leading one at the top bit |
| sticky_i | input | 1 | OR of bits below the significand |
| mode_i | input | 2 | Rounding mode code |
| trunc_i | input | 1 | Force round toward zero |
| res_o | output | INT_W | Signed integer result |
| invalid_o | output | 1 | Invalid conversion (saturated) |
| snan_o | output | 1 | Signalling NaN seen |
| inexact_o | output | 1 | Accepted result was not exact |
| rndup_o | output | 1 | Accepted magnitude was incremented |

## Verification
The bench builds the converter with an 8-bit integer, a 6-bit exponent and an 8-bit significand. That size lets it sweep all 128 normalized significands across every exponent from -3 to 9, plus one far below and one far above the range. Each sweep point is tried with both signs, both sticky values, all four modes and both truncate settings. This covers every alignment shift, every tie pattern and both saturation edges at 0x7F and 0x80. Expected values come from a remainder-versus-half comparison that shares nothing with the hardware's bit selection.

// File: rtl/fti_pkg.sv
// Package: shared encodings for the float-to-integer converter.
// Assumes class and rounding-mode codes are fixed at the block boundary.
package fti_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/fti_align.sv
// Module: fti_align
// Places the significand on the integer grid. It returns the integer part,
// the guard bit (first bit below the integer LSB) and the OR of everything
// below the guard, sticky included.
// Assumes SIG_W >= 2 and an exponent field wide enough to hold INT_W.
// Exponents >= INT_W are flagged as out of range; their integer part is don't-care.
module fti_align #(
    parameter int INT_W = 32,
    parameter int EXP_W = 12,
    parameter int SIG_W = 64
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic        [SIG_W-1:0] sig_i,
    input  logic                    sticky_i,
    output logic        [INT_W-1:0] int_o,
    output logic                    guard_o,
    output logic                    rest_o,
    output logic                    big_o
);

    localparam int SH_W = $clog2(INT_W + 1);
    localparam int L_W  = INT_W + SIG_W;
    localparam logic signed [EXP_W-1:0] EXP_LIM  = EXP_W'(INT_W);
    localparam logic signed [EXP_W-1:0] EXP_ONE  = EXP_W'(1);
    localparam logic signed [EXP_W-1:0] EXP_MIN1 = -EXP_W'(1);

    logic              tiny;
    logic signed [EXP_W-1:0] exp_p1;
    logic [SH_W-1:0]   sh;
    logic [L_W-1:0]    wide;

    // Range decode and left-shift amount (exp+1 positions).
    always_comb begin
        big_o  = (exp_i >= EXP_LIM);
        tiny   = (exp_i < EXP_MIN1);
        exp_p1 = exp_i + EXP_ONE;
        sh     = (big_o || tiny) ? '0 : SH_W'(exp_p1);
        wide   = {{INT_W{1'b0}}, sig_i} << sh;
    end

    // Split the shifted value into integer, guard and lower bits.
    always_comb begin
        if (tiny) begin
            int_o   = '0;
            guard_o = 1'b0;
            rest_o  = (|sig_i) | sticky_i;
        end else begin
            int_o   = wide[L_W-1:SIG_W];
            guard_o = wide[SIG_W-1];
            rest_o  = (|wide[SIG_W-2:0]) | sticky_i;
        end
    end

endmodule

// File: rtl/fti_round.sv
// Module: fti_round
// Decides the increment for integer rounding and reports inexactness.
// Assumes guard/rest come from fti_align and mode codes from fti_pkg.
module fti_round
    import fti_pkg::*;
(
    input  logic       lsb_i,
    input  logic       guard_i,
    input  logic       rest_i,
    input  logic       sign_i,
    input  logic [1:0] mode_i,
    input  logic       trunc_i,
    output logic       inc_o,
    output logic       inexact_o
);

    logic [1:0] eff_mode;

    // Apply the truncate override, then choose the increment per mode.
    always_comb begin
        eff_mode  = trunc_i ? RND_ZERO : mode_i;
        inexact_o = guard_i | rest_i;
        unique case (eff_mode)
            RND_NEAR: inc_o = guard_i & (rest_i | lsb_i);
            RND_ZERO: inc_o = 1'b0;
            RND_UP:   inc_o = inexact_o & ~sign_i;
            default:  inc_o = inexact_o & sign_i;
        endcase
    end

endmodule

// File: rtl/fti_saturate.sv
// Module: fti_saturate
// Applies the increment and checks the sign-dependent range. It then
// either negates the magnitude or substitutes the saturation value,
// and produces the final flags. NaN classes are forced negative.
// Assumes int_i/inc_i are only meaningful for in-range normal operands.
module fti_saturate
    import fti_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign_i,
    input  logic [2:0]       cls_i,
    input  logic             big_i,
    input  logic [INT_W-1:0] int_i,
    input  logic             inc_i,
    input  logic             inexact_i,
    output logic [INT_W-1:0] res_o,
    output logic             invalid_o,
    output logic             snan_o,
    output logic             inexact_o,
    output logic             rndup_o
);

    localparam logic [INT_W:0] HALF = (INT_W+1)'(1) << (INT_W - 1);

    logic [INT_W:0] mag;
    logic [INT_W:0] lim;
    logic           ovf;
    logic           sat_sign;
    logic           is_zero;

    // Rounded magnitude and its sign-dependent acceptance limit.
    always_comb begin
        mag = {1'b0, int_i} + {{INT_W{1'b0}}, inc_i};
        lim = HALF + {{INT_W{1'b0}}, sign_i};
    end

    // Classify the operand into zero, overflow or accepted.
    always_comb begin
        is_zero  = 1'b0;
        snan_o   = 1'b0;
        sat_sign = sign_i;
        ovf      = 1'b0;
        unique case (cls_i)
            CLS_ZERO: is_zero = 1'b1;
            CLS_NORM: ovf = big_i || (mag >= lim);
            CLS_INF:  ovf = 1'b1;
            CLS_SNAN: begin
                snan_o   = 1'b1;
                sat_sign = 1'b1;
                ovf      = 1'b1;
            end
            default: begin
                sat_sign = 1'b1;
                ovf      = 1'b1;
            end
        endcase
    end

    // Select the result word and the final flags.
    always_comb begin
        if (is_zero) begin
            res_o     = '0;
            invalid_o = 1'b0;
            inexact_o = 1'b0;
            rndup_o   = 1'b0;
        end else if (ovf) begin
            res_o     = {sat_sign, {(INT_W-1){~sat_sign}}};
            invalid_o = 1'b1;
            inexact_o = 1'b0;
            rndup_o   = 1'b0;
        end else begin
            res_o     = sign_i ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
            invalid_o = 1'b0;
            inexact_o = inexact_i;
            rndup_o   = inc_i;
        end
    end

endmodule

// File: rtl/fti_convert.sv
// Module: fti_convert (top)
// Converts an unpacked floating-point operand to a saturated signed
// integer. There is one register stage at the output.
// Assumes a normalized significand for class normal and EXP_W able to hold INT_W.
module fti_convert
    import fti_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int EXP_W = 12,
    parameter int SIG_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sign_i,
    input  logic [2:0]              cls_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    input  logic                    sticky_i,
    input  logic [1:0]              mode_i,
    input  logic                    trunc_i,
    output logic [INT_W-1:0]        res_o,
    output logic                    invalid_o,
    output logic                    snan_o,
    output logic                    inexact_o,
    output logic                    rndup_o
);

    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W-1:0] int_part;
    logic             guard;
    logic             rest;
    logic             big;
    logic             inc;
    logic             inexact_raw;
    logic [INT_W-1:0] res_d;
    logic             invalid_d;
    logic             snan_d;
    logic             inexact_d;
    logic             rndup_d;

    fti_align #(.INT_W(INT_W), .EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
        .exp_i    (exp_i),
        .sig_i    (sig_i),
        .sticky_i (sticky_i),
        .int_o    (int_part),
        .guard_o  (guard),
        .rest_o   (rest),
        .big_o    (big)
    );

    fti_round u_round (
        .lsb_i     (int_part[0]),
        .guard_i   (guard),
        .rest_i    (rest),
        .sign_i    (sign_i),
        .mode_i    (mode_i),
        .trunc_i   (trunc_i),
        .inc_o     (inc),
        .inexact_o (inexact_raw)
    );

    fti_saturate #(.INT_W(INT_W)) u_sat (
        .sign_i    (sign_i),
        .cls_i     (cls_i),
        .big_i     (big),
        .int_i     (int_part),
        .inc_i     (inc),
        .inexact_i (inexact_raw),
        .res_o     (res_d),
        .invalid_o (invalid_d),
        .snan_o    (snan_d),
        .inexact_o (inexact_d),
        .rndup_o   (rndup_d)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o     <= '0;
            invalid_o <= 1'b0;
            snan_o    <= 1'b0;
            inexact_o <= 1'b0;
            rndup_o   <= 1'b0;
        end else begin
            res_o     <= res_d;
            invalid_o <= invalid_d;
            snan_o    <= snan_d;
            inexact_o <= inexact_d;
            rndup_o   <= rndup_d;
        end
    end

    a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_ZERO) |=> (res_o == '0 && !invalid_o && !snan_o && !inexact_o && !rndup_o));

    a_r2_snan_result: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_SNAN) |=> (snan_o && invalid_o && res_o == INT_MIN));

    a_r2_snan_source: assert property (@(posedge clk) disable iff (!rst_n)
        snan_o |-> ($past(cls_i) == CLS_SNAN));

    a_r5_invalid_drops_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (!inexact_o && !rndup_o));

    a_r9_trunc_never_rounds_up: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_i |=> !rndup_o);

    a_r10_rndup_implies_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        rndup_o |-> inexact_o);

    a_r10_sign_of_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!invalid_o && res_o != '0) |-> (res_o[INT_W-1] == $past(sign_i)));

    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !invalid_o && !snan_o && !inexact_o && !rndup_o));

endmodule

// File: tb/tb_fti_convert.sv
module tb_fti_convert;

    localparam int INT_W = 8;
    localparam int EXP_W = 6;
    localparam int SIG_W = 8;
    localparam longint MAXV = (64'd1 << (INT_W-1)) - 1;
    localparam longint MINV = (64'd1 << (INT_W-1));
    localparam longint MASK = (64'd1 << INT_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sign_i = 1'b0;
    logic [2:0]              cls_i = 3'd0;
    logic signed [EXP_W-1:0] exp_i = '0;
    logic [SIG_W-1:0]        sig_i = '0;
    logic                    sticky_i = 1'b0;
    logic [1:0]              mode_i = 2'd0;
    logic                    trunc_i = 1'b0;
    logic [INT_W-1:0]        res_o;
    logic                    invalid_o, snan_o, inexact_o, rndup_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fti_convert #(.INT_W(INT_W), .EXP_W(EXP_W), .SIG_W(SIG_W)) dut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .cls_i(cls_i), .exp_i(exp_i),
        .sig_i(sig_i), .sticky_i(sticky_i), .mode_i(mode_i), .trunc_i(trunc_i),
        .res_o(res_o), .invalid_o(invalid_o), .snan_o(snan_o),
        .inexact_o(inexact_o), .rndup_o(rndup_o)
    );

    task automatic compare(input string tag, input longint e_res, input bit e_inv,
                           input bit e_snan, input bit e_inx, input bit e_up);
        checks++;
        if (res_o !== INT_W'(e_res) || invalid_o !== e_inv || snan_o !== e_snan ||
            inexact_o !== e_inx || rndup_o !== e_up) begin
            errors++;
            $display("FAIL %s: got res=%h inv=%b snan=%b inx=%b up=%b, expected res=%h inv=%b snan=%b inx=%b up=%b",
                     tag, res_o, invalid_o, snan_o, inexact_o, rndup_o,
                     INT_W'(e_res), e_inv, e_snan, e_inx, e_up);
        end
    endtask

    // Drive one operand at a falling edge, check it one rising edge later.
    task automatic run(input bit sg, input int cls, input int e, input int sg_val,
                       input bit st, input int md, input bit tr);
        longint q, rem, half, mag, lim, e_res;
        int s, eff;
        bit inx, up, inv, sn;
        string tag;
        @(negedge clk);
        sign_i = sg; cls_i = 3'(cls); exp_i = EXP_W'(e); sig_i = SIG_W'(sg_val);
        sticky_i = st; mode_i = 2'(md); trunc_i = tr;
        inv = 0; sn = 0; inx = 0; up = 0; e_res = 0; tag = "R6";
        eff = tr ? 1 : md;
        if (cls == 0) begin
            tag = "R1";
        end else if (cls == 4) begin
            tag = "R2"; sn = 1; inv = 1; e_res = MINV;
        end else if (cls >= 3) begin
            tag = "R2"; inv = 1; e_res = MINV;
        end else if (cls == 2) begin
            tag = "R3"; inv = 1; e_res = sg ? MINV : MAXV;
        end else if (e >= INT_W) begin
            tag = "R4"; inv = 1; e_res = sg ? MINV : MAXV;
        end else begin
            s = SIG_W - 1 - e;
            if (s <= 0) begin
                q = longint'(sg_val) << (-s); rem = 0; half = 0;
            end else begin
                q = longint'(sg_val) >> s;
                rem = longint'(sg_val) - (q << s);
                half = longint'(1) << (s - 1);
            end
            inx = (rem != 0) || st;
            case (eff)
                0: up = (s > 0) && ((rem > half) || (rem == half && (st || q[0])));
                1: up = 0;
                2: up = inx && !sg;
                default: up = inx && sg;
            endcase
            mag = q + longint'(up);
            lim = MINV + longint'(sg);
            if (mag >= lim) begin
                tag = inx ? "R5" : "R8";
                inv = 1; inx = 0; up = 0; e_res = sg ? MINV : MAXV;
            end else begin
                e_res = sg ? ((-mag) & MASK) : mag;
                if (e < 0) tag = "R11";
                else if (tr) tag = "R9";
                else if (md == 0 && s > 0 && rem == half && !st) tag = "R7";
                else if (mag == MINV) tag = "R8";
                else if (sg) tag = "R10";
            end
        end
        @(negedge clk);
        compare(tag, e_res, inv, sn, inx, up);
    endtask

    initial begin
        // R12: reset clears outputs even with a saturating operand present
        cls_i = 3'd2; sign_i = 1'b0;
        repeat (3) @(negedge clk);
        compare("R12", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // R12: first conversion appears one edge later
        run(0, 1, 2, 8'hA0, 0, 0, 0); // 1.25*4 = 5
        // R2/R3/R1: non-numeric classes, both signs, every mode
        for (int c = 0; c < 8; c++) begin
            if (c == 1) continue;
            for (int sg = 0; sg < 2; sg++)
                for (int md = 0; md < 4; md++)
                    run(sg[0], c, 3, 8'hB5, 1, md, 0);
        end
        // R4..R11: exhaustive sweep of normal operands
        for (int ei = -4; ei <= 10; ei++) begin
            int e;
            e = (ei == -4) ? -20 : ((ei == 10) ? 20 : ei);
            for (int sv = 128; sv < 256; sv++)
                for (int sg = 0; sg < 2; sg++)
                    for (int st = 0; st < 2; st++)
                        for (int md = 0; md < 4; md++)
                            for (int tr = 0; tr < 2; tr++)
                                run(sg[0], 1, e, sv, st[0], md, tr[0]);
        end
        // R12: synchronous reset during operation clears outputs
        @(negedge clk);
        cls_i = 3'd2; rst_n = 1'b0;
        @(negedge clk);
        compare("R12", 0, 0, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule